// File: doc/BRIEF.md
# Serial Write-Only Register Port

This block is the target side of a three-wire serial control port. A host microcontroller drives a chip select, a bit clock and a data line. The block writes the bytes it receives into a 128-entry by 8-bit register file, and the rest of the chip reads that file through a parallel port. The port cannot send data back to the host, so it has no serial readback.

Each transaction opens with a device byte that must match a fixed value. A pointer byte follows it. The pointer byte carries an auto-increment flag in bit 7 and the register index in bits 6:0. Every byte after the pointer is data, and each one lands in the register the pointer selects.

The port stays inactive until it sees a falling edge on chip select after reset. If chip select is strapped low, that edge never comes and the port never writes. All three serial inputs are synchronised into the system clock before the block uses them.

Top module: `spi_wr_regport`

## Requirements
- R1: After reset every register reads 0x00 and `port_sel` is low.
- R2: `port_sel` goes high only after a high-to-low transition of `cs_n` that follows reset, and it then stays high until the next reset. With `cs_n` held low from reset onward, no register is ever written.
- R3: While `cs_n` is low and the port is selected, the block takes one bit of `mosi` on each rising edge of `sclk`, most significant bit first, and groups the bits into bytes.
- R4: The first byte of a transaction must equal 8'b10011110. On any other value, no register changes for the rest of that transaction, up to the next time `cs_n` goes high.
- R5: The second byte loads the pointer. Bit 7 is the auto-increment flag and bits 6:0 are the register index.
- R6: Each data byte is written to the register at the pointer. When the flag is 1, the pointer then advances by one and wraps from 127 to 0.
- R7: When the flag is 0, the pointer does not move, so every data byte in the transaction overwrites the same register.
- R8: A rise of `cs_n` in the middle of a byte discards that byte without writing it. The next transaction starts again with a device byte.
- R9: `rd_data` shows the register selected by `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial bit clock from the host |
| mosi | input | 1 | Serial data from the host |
| rd_addr | input | 7 | Parallel read index |
| rd_data | output | 8 | Contents of the register at `rd_addr` |
| port_sel | output | 1 | High once this port has been selected |

## Verification
A rising edge of `sclk` takes two system clocks to pass through the synchroniser and a third to be recognised as an edge. The write for a data byte therefore lands three clock edges after the eighth bit rises. `port_sel` goes high three edges after `cs_n` falls. The bench holds each `sclk` level for four clocks. It compares the register file only after `cs_n` has been high for several clocks, long after every write has landed. Because the read port is combinational, each comparison is taken one nanosecond after `rd_addr` changes, away from any clock edge.

// File: rtl/spi_wr_regport.sv
module spi_wr_regport #(
  parameter int DW     = 8,
  parameter int SYNC   = 2,
  parameter logic [7:0] DEV_ID = 8'b1001_1110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic [DW-2:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          port_sel
);
  localparam int AW    = DW - 1;
  localparam int DEPTH = 1 << AW;
  localparam int BCW   = $clog2(DW);
  localparam logic [1:0] PH_DEV = 2'd0, PH_PTR = 2'd1, PH_DATA = 2'd2, PH_SKIP = 2'd3;

  logic [SYNC:0]   cs_q, sck_q;
  logic [SYNC-1:0] sdi_q;
  logic [BCW-1:0]  bitcnt;
  logic [DW-2:0]   shreg;
  logic [1:0]      phase;
  logic [AW-1:0]   ptr;
  logic            incr;
  logic [DW-1:0]   regs [DEPTH];

  wire cs_s      = cs_q[SYNC-1];
  wire cs_fall   = cs_q[SYNC] & ~cs_q[SYNC-1];
  wire sck_rise  = sck_q[SYNC-1] & ~sck_q[SYNC];
  wire active    = port_sel & ~cs_s;
  wire take      = active & sck_rise;
  wire [DW-1:0] rx_byte = {shreg, sdi_q[SYNC-1]};
  wire byte_done = take & (bitcnt == BCW'(DW-1));
  wire wr_en     = byte_done & (phase == PH_DATA);

  assign rd_data = regs[rd_addr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '0;
      sck_q <= '0;
      sdi_q <= '0;
    end else begin
      cs_q  <= {cs_q[SYNC-1:0], cs_n};
      sck_q <= {sck_q[SYNC-1:0], sclk};
      sdi_q <= {sdi_q[SYNC-2:0], mosi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) port_sel <= 1'b0;
    else if (cs_fall) port_sel <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
      phase  <= PH_DEV;
      ptr    <= '0;
      incr   <= 1'b0;
    end else if (cs_s) begin
      bitcnt <= '0;
      phase  <= PH_DEV;
    end else if (take) begin
      shreg  <= rx_byte[DW-2:0];
      bitcnt <= (bitcnt == BCW'(DW-1)) ? '0 : bitcnt + 1'b1;
      if (byte_done)
        case (phase)
          PH_DEV:  phase <= (rx_byte == DEV_ID) ? PH_PTR : PH_SKIP;
          PH_PTR: begin
            ptr   <= rx_byte[AW-1:0];
            incr  <= rx_byte[DW-1];
            phase <= PH_DATA;
          end
          PH_DATA: if (incr) ptr <= ptr + 1'b1;
          default: ;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[ptr] <= rx_byte;
    end
endmodule

module spi_wr_regport_chk #(parameter int AW = 7, parameter int BCW = 3) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_sel,
  input logic          cs_s,
  input logic          cs_fall,
  input logic          wr_en,
  input logic          incr,
  input logic [AW-1:0] ptr,
  input logic [BCW-1:0] bitcnt,
  input logic [1:0]    phase
);
  // R2
  sel_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) port_sel |=> port_sel);
  // R2
  sel_origin_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(port_sel) |-> $past(cs_fall));
  // R4
  skip_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n) (phase == 2'd3) |-> !wr_en);
  // R2
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (port_sel && !cs_s));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && incr) |=> ptr == AW'($past(ptr) + 1'b1));
  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !incr) |=> $stable(ptr));
  // R8
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> (bitcnt == '0 && phase == 2'd0));
endmodule

bind spi_wr_regport spi_wr_regport_chk #(.AW(AW), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .cs_s(cs_s), .cs_fall(cs_fall),
  .wr_en(wr_en), .incr(incr), .ptr(ptr), .bitcnt(bitcnt), .phase(phase)
);

// File: tb/tb_spi_wr_regport.sv
`timescale 1ns/100ps
module tb_spi_wr_regport;
  localparam int HALF = 16;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, mosi = 0;
  logic [6:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic port_sel;
  logic [7:0] model [128];
  logic [7:0] pay [8];
  int total = 0, bad = 0;
  bit finished = 0;

  spi_wr_regport dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
                      .rd_addr(rd_addr), .rd_data(rd_data), .port_sel(port_sel));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    mosi = b; #HALF; sclk = 1; #HALF; sclk = 0;
  endtask

  task automatic sbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_lo(); cs_n = 0; #HALF; endtask
  task automatic cs_hi(); #HALF; cs_n = 1; #(HALF*3); endtask

  function automatic void apply(input logic [7:0] dev, input logic [7:0] pb, input int n);
    logic [6:0] p = pb[6:0];
    if (dev != 8'h9E) return;
    for (int k = 0; k < n; k++) begin
      model[p] = pay[k];
      if (pb[7]) p = p + 1'b1;
    end
  endfunction

  task automatic xfer(input logic [7:0] dev, input logic [7:0] pb, input int n);
    cs_lo(); sbyte(dev); sbyte(pb);
    for (int k = 0; k < n; k++) sbyte(pay[k]);
    cs_hi();
    apply(dev, pb, n);
  endtask

  task automatic scan(input string req);
    int errs = 0;
    for (int a = 0; a < 128; a++) begin
      rd_addr = 7'(a); #1;
      if (rd_data != model[a]) begin
        errs++;
        if (errs < 4) $display("FAIL %s reg %0d actual=%0h expected=%0h", req, a, rd_data, model[a]);
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic do_reset(input logic cs_level);
    rst_n = 0; cs_n = cs_level; sclk = 0; #20; rst_n = 1; #20;
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 128; a++) model[a] = 8'h00;

    // R2: chip select strapped low from reset never selects the port
    do_reset(1'b0);
    chk("R1 sel after reset", port_sel, 0);
    sbyte(8'h9E); sbyte(8'h05); sbyte(8'hA5);
    #(HALF*2);
    chk("R2 strapped low no select", port_sel, 0);
    scan("R2 strapped low no write");

    do_reset(1'b1);
    chk("R1 sel after reset", port_sel, 0);
    scan("R1 registers zero");

    // R2, R3, R5, R7: flag clear, one register overwritten
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h3C;
    xfer(8'h9E, 8'h05, 3);
    chk("R2 selected after cs fall", port_sel, 1);
    rd_addr = 7'd5; #1; chk("R7 overwrite same reg", rd_data, 8'h3C);
    rd_addr = 7'd6; #1; chk("R7 neighbour untouched", rd_data, 8'h00);

    // R6: flag set with wrap 127 -> 0
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3;
    xfer(8'h9E, 8'hFE, 3);
    rd_addr = 7'd127; #1; chk("R6 burst reg127", rd_data, 8'hB2);
    rd_addr = 7'd0;   #1; chk("R6 wrap to reg0", rd_data, 8'hC3);
    scan("R6 burst");

    // R4: wrong device byte ignored
    pay[0] = 8'h77;
    xfer(8'h9F, 8'h85, 1);
    rd_addr = 7'd5; #1; chk("R4 bad device ignored", rd_data, 8'h3C);
    xfer(8'h1E, 8'h10, 1);
    rd_addr = 7'd16; #1; chk("R4 bad device ignored", rd_data, 8'h00);

    // R8: abort mid byte
    cs_lo(); sbyte(8'h9E); sbyte(8'h8A); sbyte(8'h5A);
    sbit(1); sbit(1); sbit(0);
    cs_hi();
    model[10] = 8'h5A;
    rd_addr = 7'd10; #1; chk("R8 full byte kept", rd_data, 8'h5A);
    rd_addr = 7'd11; #1; chk("R8 partial byte dropped", rd_data, 8'h00);
    pay[0] = 8'hE4;
    xfer(8'h9E, 8'h0B, 1);
    rd_addr = 7'd11; #1; chk("R8 restart after abort", rd_data, 8'hE4);

    // R3 R9: random mix
    for (int t = 0; t < 40; t++) begin
      int n = 1 + ($urandom % 5);
      logic [7:0] dev = (($urandom % 5) == 0) ? 8'($urandom) : 8'h9E;
      logic [7:0] pb = 8'($urandom);
      for (int k = 0; k < n; k++) pay[k] = 8'($urandom);
      xfer(dev, pb, n);
      if (t % 10 == 9) scan("R3 R9 random traffic");
    end
    scan("R9 final readback");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule